// File: doc/BRIEF.md
# Descriptor-Chain Memory Copy Channel

This block is a single memory-to-memory copy channel that executes a chain of transfer descriptors stored in memory. Each descriptor describes one block copy, an optional acknowledge write and the address of the next descriptor. After a descriptor's copy, the channel can write a mask value to a flag-clear register of an upstream producer. This lets a second-level copy engine acknowledge the request of a first-level engine without any processor involvement.

Execution begins on a start strobe that carries the address of the first descriptor. In software mode, that one strobe runs the whole chain. In trigger mode, the strobe only arms the channel. Each pulse on the trigger input then runs exactly one descriptor, and the input is meant to be driven by the transfer-complete pulse of another engine. A chain ends on a null next pointer. A chain whose last descriptor points back to an earlier one loops until reset.

The channel uses one simple memory port. A read returns its data one cycle after the request, and a write completes in the cycle it is issued.

Top module: `llx_dma_chan`

## Requirements
- R1: A descriptor is six 32-bit words at consecutive word addresses starting at its pointer. The words are: +0 source, +4 destination, +8 byte count, +12 acknowledge address, +16 acknowledge value, +20 next pointer. The channel reads them in that address order before any copy.
- R2: A descriptor copies (byte count >> 2) words, from ascending source addresses to ascending destination addresses. The two low bits of the byte count are ignored. Each word is written in the cycle after its read, carrying the data returned for that read.
- R3: After the last copied word, the channel writes the acknowledge value to the acknowledge address. This write is omitted when the acknowledge address is zero.
- R4: A next pointer of zero ends the chain: busy falls and the sticky done flag is set. A start with a zero first pointer sets done at once, with no memory access.
- R5: A chain whose next pointer returns to an earlier descriptor keeps running and never sets done.
- R6: With the mode input high at start, the channel is armed but idle on the memory port. Each trigger pulse then runs exactly one descriptor, after which the channel waits again.
- R7: Trigger pulses that arrive while a descriptor is running are held as one pending request. That request runs the next descriptor when the current one ends, and further pulses in the same window are absorbed.
- R8: A descriptor whose word count (byte count >> 2) is zero sets the sticky error flag and stops the chain, with no write for that descriptor and done left clear.
- R9: A start while busy is ignored. An accepted start clears done and error. Trigger pulses are ignored while idle and in software mode.
- R10: After reset, busy, done and error are low and the memory port issues no request.
- R11: The channel never issues a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| start_ptr_i | input | DW | First descriptor address, sampled with start_i |
| hw_mode_i | input | 1 | 1: one descriptor per trigger; sampled with start_i |
| trig_i | input | 1 | Trigger pulse from an upstream engine |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write request |
| mem_addr_o | output | DW | Byte address, word aligned |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after mem_rd_o |
| busy_o | output | 1 | Chain active or armed |
| done_o | output | 1 | Sticky chain-complete flag |
| err_o | output | 1 | Sticky zero-length error flag |

## Verification
Some properties are checked on every cycle by assertions. These are the exclusivity of read and write, done and error never being set together, done only while idle, each copy write following a read, and the pending trigger clearing once the channel is disarmed or waiting. Other behaviour can only be shown by the bench scenarios, which compare every memory write against a reference walk of the chain. These are the descriptor order and data, omission of the acknowledge write, one descriptor per trigger, the absorbing of a trigger burst into a single pending request, a circular chain that never finishes, and error stop on a zero-length descriptor.

// File: rtl/llx_pkg.sv
`timescale 1ns/1ps
package llx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FETCH,
    ST_CHECK,
    ST_COPY,
    ST_MASK
  } llx_state_e;

  localparam int unsigned NODE_WORDS = 6;
  localparam int unsigned F_SRC  = 0;
  localparam int unsigned F_DST  = 1;
  localparam int unsigned F_CNT  = 2;
  localparam int unsigned F_MADR = 3;
  localparam int unsigned F_MDAT = 4;
  localparam int unsigned F_NEXT = 5;
endpackage

// File: rtl/llx_node_store.sv
`timescale 1ns/1ps
module llx_node_store #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 6,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en_i,
  input  logic [IW-1:0]          cap_idx_i,
  input  logic [DW-1:0]          cap_data_i,
  output logic [NW-1:0][DW-1:0]  fields_o
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    logic [DW-1:0] q;
    logic          en;
    always_comb en = cap_en_i && (cap_idx_i == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= cap_data_i;
    end
    assign fields_o[i] = q;
  end
endmodule

// File: rtl/llx_trig_latch.sv
`timescale 1ns/1ps
module llx_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic armed_i,
  input  logic waiting_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    if (!armed_i || waiting_i) pend_d = 1'b0;
    else                       pend_d = pend_q | trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_pend_disarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> !pend_o);
  assert_pend_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_i |=> !pend_o);
endmodule

// File: rtl/llx_seq.sv
`timescale 1ns/1ps
module llx_seq
  import llx_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = NODE_WORDS,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [DW-1:0]         start_ptr_i,
  input  logic                  hw_mode_i,
  input  logic                  trig_i,
  input  logic                  pend_i,
  input  logic [NW-1:0][DW-1:0] fields_i,
  input  logic [DW-1:0]         mem_rdata_i,
  output logic                  mem_rd_o,
  output logic                  mem_wr_o,
  output logic [DW-1:0]         mem_addr_o,
  output logic [DW-1:0]         mem_wdata_o,
  output logic                  cap_en_o,
  output logic [IW-1:0]         cap_idx_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  armed_o,
  output logic                  waiting_o
);
  llx_state_e    st_q, st_d;
  logic          phase_q, phase_d;
  logic [IW-1:0] widx_q, widx_d;
  logic [DW-1:0] node_q, node_d;
  logic [DW-1:0] src_q, src_d;
  logic [DW-1:0] dst_q, dst_d;
  logic [DW-1:0] rem_q, rem_d;
  logic          hw_q, hw_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [DW-1:0] cnt_words;

  always_comb cnt_words = fields_i[F_CNT] >> 2;

  always_comb begin
    st_d = st_q; phase_d = phase_q; widx_d = widx_q; node_d = node_q;
    src_d = src_q; dst_d = dst_q; rem_d = rem_q; hw_d = hw_q;
    done_d = done_q; err_d = err_q;
    mem_rd_o = 1'b0; mem_wr_o = 1'b0; mem_addr_o = '0; mem_wdata_o = '0;
    cap_en_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          err_d = 1'b0;
          if (start_ptr_i == '0) begin
            done_d = 1'b1;
          end else begin
            done_d  = 1'b0;
            node_d  = start_ptr_i;
            hw_d    = hw_mode_i;
            widx_d  = '0;
            phase_d = 1'b0;
            st_d    = hw_mode_i ? ST_WAIT : ST_FETCH;
          end
        end
      end
      ST_WAIT: begin
        if (trig_i || pend_i) st_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (!phase_q) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = node_q + DW'({widx_q, 2'b00});
          phase_d    = 1'b1;
        end else begin
          cap_en_o = 1'b1;
          phase_d  = 1'b0;
          if (widx_q == IW'(NW - 1)) st_d = ST_CHECK;
          else                       widx_d = widx_q + 1'b1;
        end
      end
      ST_CHECK: begin
        if (cnt_words == '0) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          src_d   = fields_i[F_SRC];
          dst_d   = fields_i[F_DST];
          rem_d   = cnt_words;
          phase_d = 1'b0;
          st_d    = ST_COPY;
        end
      end
      ST_COPY: begin
        if (!phase_q) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = src_q;
          phase_d    = 1'b1;
        end else begin
          mem_wr_o    = 1'b1;
          mem_addr_o  = dst_q;
          mem_wdata_o = mem_rdata_i;
          src_d       = src_q + DW'(4);
          dst_d       = dst_q + DW'(4);
          rem_d       = rem_q - 1'b1;
          phase_d     = 1'b0;
          if (rem_q == DW'(1)) st_d = ST_MASK;
        end
      end
      ST_MASK: begin
        if (fields_i[F_MADR] != '0) begin
          mem_wr_o    = 1'b1;
          mem_addr_o  = fields_i[F_MADR];
          mem_wdata_o = fields_i[F_MDAT];
        end
        if (fields_i[F_NEXT] == '0) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          node_d  = fields_i[F_NEXT];
          widx_d  = '0;
          phase_d = 1'b0;
          st_d    = hw_q ? ST_WAIT : ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; phase_q <= 1'b0; widx_q <= '0; node_q <= '0;
      src_q <= '0; dst_q <= '0; rem_q <= '0; hw_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; phase_q <= phase_d; widx_q <= widx_d; node_q <= node_d;
      src_q <= src_d; dst_q <= dst_d; rem_q <= rem_d; hw_q <= hw_d;
      done_q <= done_d; err_q <= err_d;
    end
  end

  assign cap_idx_o = widx_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign armed_o   = hw_q && (st_q != ST_IDLE);
  assign waiting_o = (st_q == ST_WAIT);

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_err_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o);
  assert_copy_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && st_q == ST_COPY) |-> $past(mem_rd_o));
endmodule

// File: rtl/llx_dma_chan.sv
`timescale 1ns/1ps
module llx_dma_chan
  import llx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] start_ptr_i,
  input  logic          hw_mode_i,
  input  logic          trig_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned NW = NODE_WORDS;
  localparam int unsigned IW = $clog2(NW);

  logic                  cap_en;
  logic [IW-1:0]         cap_idx;
  logic [NW-1:0][DW-1:0] fields;
  logic                  pend, armed, waiting;

  llx_node_store #(.DW(DW), .NW(NW)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en), .cap_idx_i(cap_idx),
    .cap_data_i(mem_rdata_i), .fields_o(fields)
  );

  llx_trig_latch u_trig (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .armed_i(armed),
    .waiting_i(waiting), .pend_o(pend)
  );

  llx_seq #(.DW(DW), .NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ptr_i(start_ptr_i),
    .hw_mode_i(hw_mode_i), .trig_i(trig_i), .pend_i(pend), .fields_i(fields),
    .mem_rdata_i(mem_rdata_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .cap_en_o(cap_en),
    .cap_idx_o(cap_idx), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .armed_o(armed), .waiting_o(waiting)
  );
endmodule

// File: tb/llx_dma_chan_test.sv
`timescale 1ns/1ps
module llx_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n, start_i, hw_mode_i, trig_i;
  logic [31:0] start_ptr_i;
  logic        mem_rd_o, mem_wr_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        busy_o, done_o, err_o;

  always #2 clk = ~clk;

  llx_dma_chan #(.DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ptr_i(start_ptr_i),
    .hw_mode_i(hw_mode_i), .trig_i(trig_i), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  logic [31:0] mem    [0:255];
  logic [31:0] shadow [0:255];
  logic [31:0] rd_q;
  logic [31:0] exp_a[$];
  logic [31:0] exp_d[$];
  int  n_chk = 0, n_fail = 0, wr_seen = 0, cyc = 0;
  bit  allow_extra = 1'b0, finished = 1'b0;

  assign mem_rdata_i = rd_q;

  always @(posedge clk) begin
    if (mem_wr_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
    if (mem_rd_o) rd_q <= mem[mem_addr_o[9:2]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: every write is compared, on the clock it appears, with the
  // next entry of the behaviourally computed write list.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(mem_rd_o && mem_wr_o), "R11 rd/wr exclusive", {31'b0, mem_wr_o}, 32'h0);
      if (mem_wr_o) begin
        wr_seen++;
        if (exp_a.size() > 0) begin
          logic [31:0] ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(mem_addr_o == ea, "R1/R2/R3 write address", mem_addr_o, ea);
          chk(mem_wdata_o == ed, "R1/R2/R3 write data", mem_wdata_o, ed);
        end else if (!allow_extra) begin
          chk(1'b0, "R3/R8 unexpected write", mem_addr_o, 32'h0);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic put_node(input int a, input logic [31:0] s, d, c, ma, md, nx);
    mem[a/4]     = s;  mem[a/4 + 1] = d;  mem[a/4 + 2] = c;
    mem[a/4 + 3] = ma; mem[a/4 + 4] = md; mem[a/4 + 5] = nx;
  endtask

  task automatic build_expect(input logic [31:0] ptr, input int max_nodes);
    logic [31:0] p;
    for (int i = 0; i < 256; i++) shadow[i] = mem[i];
    exp_a.delete(); exp_d.delete();
    p = ptr;
    for (int n = 0; n < max_nodes && p != 0; n++) begin
      int b;
      logic [31:0] s, d, cw;
      b  = int'(p >> 2);
      s  = shadow[b]; d = shadow[b + 1]; cw = shadow[b + 2] >> 2;
      if (cw == 0) break;
      for (int w = 0; w < int'(cw); w++) begin
        logic [31:0] v;
        v = shadow[int'(s >> 2) + w];
        exp_a.push_back(d + 32'(4 * w));
        exp_d.push_back(v);
        shadow[int'(d >> 2) + w] = v;
      end
      if (shadow[b + 3] != 0) begin
        exp_a.push_back(shadow[b + 3]);
        exp_d.push_back(shadow[b + 4]);
        shadow[int'(shadow[b + 3] >> 2)] = shadow[b + 4];
      end
      p = shadow[b + 5];
    end
  endtask

  task automatic kick(input logic [31:0] ptr, input bit hw);
    @(posedge clk); #1;
    start_i = 1'b1; start_ptr_i = ptr; hw_mode_i = hw;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1; trig_i = 1'b1;
    @(posedge clk); #1; trig_i = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy_o && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; hw_mode_i = 1'b0; trig_i = 1'b0;
    start_ptr_i = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk(!busy_o && !done_o && !err_o, "R10 reset flags",
        {29'b0, busy_o, done_o, err_o}, 32'h0);
    chk(!mem_rd_o && !mem_wr_o, "R10 idle port", {30'b0, mem_rd_o, mem_wr_o}, 32'h0);

    // Scenario: software chain of two nodes, second without acknowledge
    put_node(32'h100, 32'h200, 32'h300, 32'd12, 32'h3F0, 32'h1, 32'h140);
    put_node(32'h140, 32'h220, 32'h340, 32'd9,  32'h0,   32'h0, 32'h0);
    build_expect(32'h100, 16);
    wr_seen = 0;
    kick(32'h100, 1'b0);
    repeat (5) @(posedge clk);
    kick(32'h180, 1'b1);            // R9 start while busy is ignored
    wait_idle();
    chk(exp_a.size() == 0, "R2 all copies done", exp_a.size(), 0);
    chk(wr_seen == 6, "R3 ack write count", wr_seen, 6);
    chk(done_o && !busy_o && !err_o, "R4 chain end flags",
        {29'b0, busy_o, done_o, err_o}, 32'h2);

    // Scenario: zero-length node stops the chain
    put_node(32'h180, 32'h240, 32'h380, 32'd8, 32'h3F4, 32'h2, 32'h1C0);
    put_node(32'h1C0, 32'h260, 32'h3A0, 32'd3, 32'h3F8, 32'h3, 32'h100);
    build_expect(32'h180, 16);
    wr_seen = 0;
    kick(32'h180, 1'b0);
    @(negedge clk);
    chk(!done_o && busy_o, "R9 start clears done", {30'b0, busy_o, done_o}, 32'h2);
    wait_idle();
    chk(err_o && !done_o, "R8 error flag", {30'b0, done_o, err_o}, 32'h1);
    chk(wr_seen == 3, "R8 no writes for bad node", wr_seen, 3);
    kick(32'h0, 1'b0);
    @(negedge clk);
    chk(done_o && !err_o && !busy_o, "R4 null start / R9 err clear",
        {29'b0, busy_o, done_o, err_o}, 32'h2);

    // Scenario: trigger mode, one node per pulse, burst absorbed once
    put_node(32'h100, 32'h200, 32'h300, 32'd8, 32'h3F8, 32'h4, 32'h140);
    put_node(32'h140, 32'h210, 32'h320, 32'd4, 32'h0,   32'h0, 32'h180);
    put_node(32'h180, 32'h218, 32'h330, 32'd8, 32'h3FC, 32'h8, 32'h1C0);
    put_node(32'h1C0, 32'h220, 32'h340, 32'd4, 32'h0,   32'h0, 32'h0);
    build_expect(32'h100, 16);
    wr_seen = 0;
    pulse_trig();
    repeat (20) @(negedge clk);
    chk(wr_seen == 0 && !busy_o, "R9 trigger while idle ignored", wr_seen, 0);
    kick(32'h100, 1'b1);
    repeat (40) @(negedge clk);
    chk(wr_seen == 0 && busy_o, "R6 armed waits for trigger", wr_seen, 0);
    pulse_trig();
    repeat (100) @(negedge clk);
    chk(wr_seen == 3 && busy_o, "R6 one node per trigger", wr_seen, 3);
    pulse_trig();
    repeat (3) @(posedge clk);
    pulse_trig();
    pulse_trig();
    repeat (150) @(negedge clk);
    chk(wr_seen == 7 && busy_o && !done_o, "R7 burst served once", wr_seen, 7);
    pulse_trig();
    wait_idle();
    chk(wr_seen == 8 && done_o, "R6 last node ends chain", wr_seen, 8);

    // Scenario: circular chain runs indefinitely
    put_node(32'h100, 32'h200, 32'h300, 32'd4, 32'h3F0, 32'h10, 32'h140);
    put_node(32'h140, 32'h204, 32'h304, 32'd4, 32'h0,   32'h0,  32'h100);
    build_expect(32'h100, 6);
    allow_extra = 1'b1;
    wr_seen = 0;
    kick(32'h100, 1'b0);
    repeat (300) @(negedge clk);
    chk(exp_a.size() == 0, "R5 three laps written", exp_a.size(), 0);
    chk(busy_o && !done_o, "R5 still running", {30'b0, busy_o, done_o}, 32'h2);
    do_reset();
    allow_extra = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R10 reset stops loop",
        {29'b0, busy_o, done_o, err_o}, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule